// File: doc/BRIEF.md
# Shared Bus Interconnect with Round-Robin Arbitration

This block lets several bus masters reach several slaves through one shared bus, in the classic single-cycle handshake style: a master raises `cyc` for the length of its bus tenure and `stb` for each transfer. A slave answers with `ack`, and with read data on reads. A round-robin arbiter picks one master at a time. That owner's address, write data, byte selects and write enable are driven onto the shared slave-side bus.

The two most significant address bits select one of four slave slots. Slots 0, 1 and 3 hold slaves; slot 2 is empty. The slot select is folded into each slave's own `cyc` and `stb`, so only the addressed slave sees a cycle. The acknowledge and read data of the addressed slave go back to the owning master alone. An access that lands in the empty slot is answered by the interconnect itself, so the bus never waits on a slave that is not there.

The arbiter is a two-state machine. `ARB_IDLE` means no tenure is in progress, and the last owner's grant is kept. `ARB_OWNED` means the owner's `cyc` is honoured. There are three transitions:

- claim (`ARB_IDLE` to `ARB_OWNED`): some master requests.
- hand-over (`ARB_OWNED` to `ARB_OWNED` with a new owner): the owner drops `cyc` while others request.
- release (`ARB_OWNED` to `ARB_IDLE`): the owner drops `cyc` and nobody else requests.

Top module: `shared_bus_xbar`

## Requirements
- R1: After reset no slave `cyc`/`stb` and no master `ack` is asserted. The grant points at master N_MST-1, so the first search starts at master 0.
- R2: A new owner is chosen only at a clock edge where no tenure is held. The search starts at the master after the current owner and wraps, so the current owner comes last. The grant (one-hot `m_gnt`, bit k for master k) changes at that edge.
- R3: While the owner keeps its `cyc` high, the grant does not move, whatever the other masters request.
- R4: During a tenure the shared bus carries the owner's address, write data, byte selects and write enable.
- R5: Address bits [ADDR_W-1:ADDR_W-2] give the slot number. `s_cyc[i]` and `s_stb[i]` (bit i for slot i) can be high only for the addressed, populated slot, and only while the owner's `cyc` (and, for `stb`, its `stb`) is high in `ARB_OWNED`.
- R6: Populated slots are 0, 1 and 3. An access to slot 2 never raises any slave `cyc`. The owner is acknowledged in the same cycle its `stb` is seen during a tenure, with all-zero read data, and the slot-2 return inputs are ignored.
- R7: The addressed slave's `ack` and read data reach only the owning master. Every other master sees `ack` low and read data zero.
- R8: With no master requesting, the grant stays with the last owner and no slave cycle is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_adr | input | N_MST*ADDR_W | Master addresses, master k at slice k |
| m_dat_w | input | N_MST*DATA_W | Master write data |
| m_sel | input | N_MST*SEL_W | Master byte selects |
| m_we | input | N_MST | Master write enables |
| m_cyc | input | N_MST | Master bus-tenure requests |
| m_stb | input | N_MST | Master transfer strobes |
| m_dat_r | output | N_MST*DATA_W | Read data per master |
| m_ack | output | N_MST | Acknowledge per master |
| m_gnt | output | N_MST | One-hot grant |
| s_adr | output | ADDR_W | Shared address |
| s_dat_w | output | DATA_W | Shared write data |
| s_sel | output | SEL_W | Shared byte selects |
| s_we | output | 1 | Shared write enable |
| s_cyc | output | N_SLOT | Per-slot gated cycle |
| s_stb | output | N_SLOT | Per-slot gated strobe |
| s_dat_r | input | N_SLOT*DATA_W | Read data per slot |
| s_ack | input | N_SLOT | Acknowledge per slot |

## Verification
The bench builds the block with its defaults: four masters, 16-bit addresses, 32-bit data, and the slot mask 4'b1011. This makes the full wrap of the round-robin search reachable, along with a hand-over through every master in turn. It also exercises the empty slot sitting between populated ones. That slot's inputs are driven with a constant acknowledge and non-zero data, so any leak of them through the return path would show at a master.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter
    import xbar_pkg::*;
#(
    parameter int N_MST = 4,
    parameter int MST_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    output logic [MST_W-1:0] owner,
    output logic             busy
);

    arb_state_e       state_q, state_d;
    logic [MST_W-1:0] owner_q, owner_d;
    logic             pick_found;
    logic [MST_W-1:0] pick_idx;

    // Search starts at the master after the current owner and wraps.
    always_comb begin
        pick_found = 1'b0;
        pick_idx   = owner_q;
        for (int k = 1; k <= N_MST; k++) begin
            int cand;
            cand = (int'(owner_q) + k) % N_MST;
            if (!pick_found && req[cand]) begin
                pick_found = 1'b1;
                pick_idx   = MST_W'(cand);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (pick_found) begin            // claim
                    state_d = ARB_OWNED;
                    owner_d = pick_idx;
                end
            end
            ARB_OWNED: begin
                if (!req[owner_q]) begin
                    if (pick_found) begin
                        owner_d = pick_idx;      // hand-over
                    end else begin
                        state_d = ARB_IDLE;      // release
                    end
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= MST_W'(N_MST - 1);
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        owner = owner_q;
        busy  = (state_q == ARB_OWNED);
    end

endmodule

// File: rtl/master_mux.sv
module master_mux #(
    parameter int N_MST  = 4,
    parameter int MST_W  = 2,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4
) (
    input  logic [N_MST*ADDR_W-1:0] m_adr,
    input  logic [N_MST*DATA_W-1:0] m_dat_w,
    input  logic [N_MST*SEL_W-1:0]  m_sel,
    input  logic [N_MST-1:0]        m_we,
    input  logic [N_MST-1:0]        m_cyc,
    input  logic [N_MST-1:0]        m_stb,
    input  logic [MST_W-1:0]        owner,
    output logic [ADDR_W-1:0]       bus_adr,
    output logic [DATA_W-1:0]       bus_dat_w,
    output logic [SEL_W-1:0]        bus_sel,
    output logic                    bus_we,
    output logic                    bus_cyc,
    output logic                    bus_stb
);

    always_comb begin
        bus_adr   = m_adr[owner*ADDR_W +: ADDR_W];
        bus_dat_w = m_dat_w[owner*DATA_W +: DATA_W];
        bus_sel   = m_sel[owner*SEL_W +: SEL_W];
        bus_we    = m_we[owner];
        bus_cyc   = m_cyc[owner];
        bus_stb   = m_stb[owner];
    end

endmodule

// File: rtl/slot_decoder.sv
module slot_decoder #(
    parameter int              DEC_W        = 2,
    parameter int              N_SLOT       = 4,
    parameter logic [N_SLOT-1:0] SLOT_PRESENT = 4'b1011
) (
    input  logic [DEC_W-1:0]  slot,
    input  logic              cyc_act,
    input  logic              stb_act,
    output logic [N_SLOT-1:0] hit,
    output logic [N_SLOT-1:0] s_cyc,
    output logic [N_SLOT-1:0] s_stb,
    output logic              hole
);

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        if (SLOT_PRESENT[i]) begin : g_pop
            assign hit[i] = (slot == DEC_W'(i));
        end else begin : g_empty
            assign hit[i] = 1'b0;
        end
        assign s_cyc[i] = cyc_act & hit[i];
        assign s_stb[i] = stb_act & hit[i];
    end

    assign hole = stb_act & ~(|hit);

endmodule

// File: rtl/return_path.sv
module return_path #(
    parameter int N_MST  = 4,
    parameter int MST_W  = 2,
    parameter int N_SLOT = 4,
    parameter int DATA_W = 32
) (
    input  logic [N_SLOT*DATA_W-1:0] s_dat_r,
    input  logic [N_SLOT-1:0]        s_ack,
    input  logic [N_SLOT-1:0]        hit,
    input  logic                     stb_act,
    input  logic                     hole,
    input  logic [MST_W-1:0]         owner,
    output logic [N_MST*DATA_W-1:0]  m_dat_r,
    output logic [N_MST-1:0]         m_ack
);

    logic [DATA_W-1:0] bus_dat;
    logic              bus_ack;

    always_comb begin
        bus_dat = '0;
        bus_ack = hole;
        for (int i = 0; i < N_SLOT; i++) begin
            if (hit[i]) begin
                bus_dat = s_dat_r[i*DATA_W +: DATA_W];
                bus_ack = bus_ack | (s_ack[i] & stb_act);
            end
        end
    end

    for (genvar j = 0; j < N_MST; j++) begin : g_mst
        logic mine;
        assign mine = stb_act && (owner == MST_W'(j));
        assign m_ack[j] = mine & bus_ack;
        assign m_dat_r[j*DATA_W +: DATA_W] = mine ? bus_dat : '0;
    end

endmodule

// File: rtl/shared_bus_xbar.sv
module shared_bus_xbar #(
    parameter int              N_MST        = 4,
    parameter int              ADDR_W       = 16,
    parameter int              DATA_W       = 32,
    parameter int              DEC_W        = 2,
    parameter logic [(1<<DEC_W)-1:0] SLOT_PRESENT = 4'b1011,
    localparam int             SEL_W        = DATA_W / 8,
    localparam int             N_SLOT       = 1 << DEC_W,
    localparam int             MST_W        = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_MST*ADDR_W-1:0]  m_adr,
    input  logic [N_MST*DATA_W-1:0]  m_dat_w,
    input  logic [N_MST*SEL_W-1:0]   m_sel,
    input  logic [N_MST-1:0]         m_we,
    input  logic [N_MST-1:0]         m_cyc,
    input  logic [N_MST-1:0]         m_stb,
    output logic [N_MST*DATA_W-1:0]  m_dat_r,
    output logic [N_MST-1:0]         m_ack,
    output logic [N_MST-1:0]         m_gnt,
    output logic [ADDR_W-1:0]        s_adr,
    output logic [DATA_W-1:0]        s_dat_w,
    output logic [SEL_W-1:0]         s_sel,
    output logic                     s_we,
    output logic [N_SLOT-1:0]        s_cyc,
    output logic [N_SLOT-1:0]        s_stb,
    input  logic [N_SLOT*DATA_W-1:0] s_dat_r,
    input  logic [N_SLOT-1:0]        s_ack
);

    logic [MST_W-1:0]  owner;
    logic              busy;
    logic              bus_cyc, bus_stb;
    logic              cyc_act, stb_act;
    logic [N_SLOT-1:0] hit;
    logic              hole;

    rr_arbiter #(.N_MST(N_MST), .MST_W(MST_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (m_cyc),
        .owner (owner),
        .busy  (busy)
    );

    master_mux #(
        .N_MST(N_MST), .MST_W(MST_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_mux (
        .m_adr     (m_adr),
        .m_dat_w   (m_dat_w),
        .m_sel     (m_sel),
        .m_we      (m_we),
        .m_cyc     (m_cyc),
        .m_stb     (m_stb),
        .owner     (owner),
        .bus_adr   (s_adr),
        .bus_dat_w (s_dat_w),
        .bus_sel   (s_sel),
        .bus_we    (s_we),
        .bus_cyc   (bus_cyc),
        .bus_stb   (bus_stb)
    );

    assign cyc_act = busy & bus_cyc;
    assign stb_act = cyc_act & bus_stb;

    slot_decoder #(
        .DEC_W(DEC_W), .N_SLOT(N_SLOT), .SLOT_PRESENT(SLOT_PRESENT)
    ) u_dec (
        .slot    (s_adr[ADDR_W-1 -: DEC_W]),
        .cyc_act (cyc_act),
        .stb_act (stb_act),
        .hit     (hit),
        .s_cyc   (s_cyc),
        .s_stb   (s_stb),
        .hole    (hole)
    );

    return_path #(
        .N_MST(N_MST), .MST_W(MST_W), .N_SLOT(N_SLOT), .DATA_W(DATA_W)
    ) u_ret (
        .s_dat_r (s_dat_r),
        .s_ack   (s_ack),
        .hit     (hit),
        .stb_act (stb_act),
        .hole    (hole),
        .owner   (owner),
        .m_dat_r (m_dat_r),
        .m_ack   (m_ack)
    );

    for (genvar j = 0; j < N_MST; j++) begin : g_gnt
        assign m_gnt[j] = (owner == MST_W'(j));
    end

endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
    parameter int N_MST  = 4,
    parameter int N_SLOT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_MST-1:0]  m_cyc,
    input logic [N_MST-1:0]  m_stb,
    input logic [N_MST-1:0]  m_gnt,
    input logic [N_MST-1:0]  m_ack,
    input logic [N_SLOT-1:0] s_cyc
);

    p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(m_gnt));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|s_cyc) && (|(m_gnt & m_cyc))) |=> $stable(m_gnt));

    p_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_cyc));

    p_slot_needs_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_cyc) |-> (|(m_gnt & m_cyc)));

    p_ack_to_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_ack) |-> (m_ack == m_gnt));

    p_ack_needs_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_ack) |-> (|(m_ack & m_stb & m_cyc)));

    p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cyc == '0) |=> $stable(m_gnt));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cyc == '0) |-> (s_cyc == '0));

endmodule

bind shared_bus_xbar xbar_checker #(.N_MST(N_MST), .N_SLOT(N_SLOT)) u_xbar_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .m_cyc (m_cyc),
    .m_stb (m_stb),
    .m_gnt (m_gnt),
    .m_ack (m_ack),
    .s_cyc (s_cyc)
);

// File: tb/test_shared_bus_xbar.sv
module test_shared_bus_xbar;

    localparam int N_MST  = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 4;
    localparam int N_SLOT = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [N_MST*ADDR_W-1:0]  m_adr = '0;
    logic [N_MST*DATA_W-1:0]  m_dat_w = '0;
    logic [N_MST*SEL_W-1:0]   m_sel = '0;
    logic [N_MST-1:0]         m_we = '0;
    logic [N_MST-1:0]         m_cyc = '0;
    logic [N_MST-1:0]         m_stb = '0;
    logic [N_MST*DATA_W-1:0]  m_dat_r;
    logic [N_MST-1:0]         m_ack;
    logic [N_MST-1:0]         m_gnt;
    logic [ADDR_W-1:0]        s_adr;
    logic [DATA_W-1:0]        s_dat_w;
    logic [SEL_W-1:0]         s_sel;
    logic                     s_we;
    logic [N_SLOT-1:0]        s_cyc;
    logic [N_SLOT-1:0]        s_stb;
    logic [N_SLOT*DATA_W-1:0] s_dat_r;
    logic [N_SLOT-1:0]        s_ack;

    int  vectors = 0;
    int  errors  = 0;
    bit  done    = 1'b0;
    bit  slot2_touched = 1'b0;
    logic [N_SLOT-1:0]  sl_ack = '0;
    logic [DATA_W-1:0]  sl_wdat [N_SLOT];
    logic [SEL_W-1:0]   sl_wsel [N_SLOT];

    always #5 clk = ~clk;

    shared_bus_xbar i_shared_bus_xbar (
        .clk(clk), .rst_n(rst_n),
        .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel), .m_we(m_we),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_dat_r(m_dat_r), .m_ack(m_ack),
        .m_gnt(m_gnt), .s_adr(s_adr), .s_dat_w(s_dat_w), .s_sel(s_sel),
        .s_we(s_we), .s_cyc(s_cyc), .s_stb(s_stb),
        .s_dat_r(s_dat_r), .s_ack(s_ack)
    );

    // Slave models: populated slots ack one cycle after strobe; slot 2 is junk.
    for (genvar i = 0; i < N_SLOT; i++) begin : g_sl
        if (i == 2) begin : g_junk
            assign s_ack[i] = 1'b1;
            assign s_dat_r[i*DATA_W +: DATA_W] = 32'hDEAD_BEEF;
        end else begin : g_real
            assign s_ack[i] = sl_ack[i];
            assign s_dat_r[i*DATA_W +: DATA_W] =
                32'hC0DE_0000 | (32'(i) << 12) | {20'd0, s_adr[11:0]};
            always @(posedge clk) begin
                if (!rst_n) begin
                    sl_ack[i] <= 1'b0;
                end else begin
                    sl_ack[i] <= s_stb[i] & ~sl_ack[i];
                    if (s_stb[i] && s_we && !sl_ack[i]) begin
                        sl_wdat[i] <= s_dat_w;
                        sl_wsel[i] <= s_sel;
                    end
                end
            end
        end
    end

    always @(posedge clk) if (s_cyc[2] || s_stb[2]) slot2_touched = 1'b1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int gnt_idx(input logic [N_MST-1:0] g);
        for (int k = 0; k < N_MST; k++) if (g[k]) return k;
        return -1;
    endfunction

    task automatic access(input int m, input logic [15:0] adr, input bit we,
                          input logic [31:0] wd, input logic [3:0] sel,
                          output logic [31:0] rd, output int lat,
                          output logic [N_MST-1:0] ack_seen);
        @(negedge clk);
        m_adr[m*ADDR_W +: ADDR_W] = adr;
        m_dat_w[m*DATA_W +: DATA_W] = wd;
        m_sel[m*SEL_W +: SEL_W] = sel;
        m_we[m] = we;
        m_cyc[m] = 1'b1;
        m_stb[m] = 1'b1;
        lat = 0;
        @(negedge clk);
        while (!m_ack[m] && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        rd = m_dat_r[m*DATA_W +: DATA_W];
        ack_seen = m_ack;
        chk(s_adr == adr && s_we == we && s_sel == sel && s_dat_w == wd,
            "R4 shared bus carries owner fields", {s_adr, 12'd0, s_sel}, {adr, 12'd0, sel});
        m_cyc[m] = 1'b0;
        m_stb[m] = 1'b0;
        m_we[m]  = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(s_cyc == 0 && s_stb == 0, "R1 no slave cycle after reset", 32'(s_cyc), 0);
        chk(m_ack == 0, "R1 no ack after reset", 32'(m_ack), 0);
        chk(m_gnt == 4'b1000, "R1 grant on last master", 32'(m_gnt), 32'h8);
        repeat (3) @(negedge clk);
        chk(m_gnt == 4'b1000 && s_cyc == 0, "R8 idle keeps grant", 32'(m_gnt), 32'h8);
    endtask

    task automatic t_reads;
        logic [31:0] rd; int lat; logic [N_MST-1:0] acks;
        access(0, 16'h0123, 1'b0, 32'h0, 4'hF, rd, lat, acks);
        chk(rd == 32'hC0DE_0123, "R5 slot0 read data", rd, 32'hC0DE_0123);
        chk(lat == 1, "R5 slot0 ack after one slave cycle", 32'(lat), 1);
        chk(acks == 4'b0001, "R7 only owner acked", 32'(acks), 1);
        access(1, 16'h4ABC, 1'b0, 32'h0, 4'hF, rd, lat, acks);
        chk(rd == 32'hC0DE_1ABC, "R5 slot1 read data", rd, 32'hC0DE_1ABC);
        access(3, 16'hC777, 1'b0, 32'h0, 4'hF, rd, lat, acks);
        chk(rd == 32'hC0DE_3777, "R5 slot3 read data", rd, 32'hC0DE_3777);
        chk(acks == 4'b1000, "R7 only master3 acked", 32'(acks), 8);
    endtask

    task automatic t_write;
        logic [31:0] rd; int lat; logic [N_MST-1:0] acks;
        access(2, 16'h4055, 1'b1, 32'h1234_5678, 4'b0110, rd, lat, acks);
        chk(sl_wdat[1] == 32'h1234_5678, "R4 slot1 captured write data",
            sl_wdat[1], 32'h1234_5678);
        chk(sl_wsel[1] == 4'b0110, "R4 slot1 captured byte selects",
            32'(sl_wsel[1]), 32'h6);
    endtask

    task automatic t_hole;
        logic [31:0] rd; int lat; logic [N_MST-1:0] acks;
        access(1, 16'h8042, 1'b0, 32'h0, 4'hF, rd, lat, acks);
        chk(lat == 0, "R6 empty slot acks at once", 32'(lat), 0);
        chk(rd == 32'h0, "R6 empty slot returns zero", rd, 0);
        chk(!slot2_touched, "R6 empty slot never sees a cycle", 32'(slot2_touched), 0);
    endtask

    task automatic t_round_robin;
        int g, c;
        logic [N_MST-1:0] g0;
        @(negedge clk);
        g = gnt_idx(m_gnt);
        m_adr = {4{16'h0010}};
        m_cyc = 4'hF;
        @(negedge clk);
        c = (g + 1) % N_MST;
        chk(m_gnt == 4'(1 << c), "R2 search starts after owner", 32'(m_gnt), 32'(1 << c));
        g0 = m_gnt;
        repeat (3) @(negedge clk);
        chk(m_gnt == g0, "R3 grant held while cyc high", 32'(m_gnt), 32'(g0));
        // all masters strobe; only the owner may be acked
        m_stb = 4'hF;
        for (int w = 0; w < 10 && !m_ack[c]; w++) @(negedge clk);
        chk(m_ack == 4'(1 << c), "R7 ack only to owner under contention",
            32'(m_ack), 32'(1 << c));
        chk(m_dat_r[((c+1)%4)*DATA_W +: DATA_W] == 0, "R7 non-owner data zero",
            m_dat_r[((c+1)%4)*DATA_W +: DATA_W], 0);
        m_stb = 4'h0;
        for (int step = 0; step < 3; step++) begin
            m_cyc[c] = 1'b0;
            @(negedge clk);
            c = (c + 1) % N_MST;
            chk(m_gnt == 4'(1 << c), "R2 hand-over to next master",
                32'(m_gnt), 32'(1 << c));
        end
        m_cyc = 4'h0;
        repeat (3) @(negedge clk);
        chk(m_gnt == 4'(1 << c) && s_cyc == 0, "R8 grant kept with no requests",
            32'(m_gnt), 32'(1 << c));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_reads();
        t_write();
        t_hole();
        t_round_robin();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule